// File: doc/BRIEF.md
# Double-Buffer Transmit Admission Controller

This block is the producer-side flow control for a transmit buffer with two slots, shared with a separate consumer engine. It keeps a wrapping count of packets handed over. It also registers the consumer's progress count, which arrives in the low bits of a status word that the consumer owns. The number of occupied slots is the modulo difference of the two counts; no full or empty flag is shared between the two sides.

A packet arrives as a sequence of beats on a valid/ready handshake. The last beat is marked. The first beat of a packet is admitted only while fewer than two slots are occupied. Once a packet is admitted, the rest of its beats pass without a further check. Every accepted beat raises a write enable together with the target slot index. The slot alternates from one packet to the next, starting with slot 0. When the final beat is accepted, the input count advances and a one-cycle doorbell pulse goes to the consumer on the following cycle.

Top module: `dbuf_tx_admit`

## Requirements
- R1: While reset is asserted and right after it, the input count and the sampled output count are 0, the slot index is 0, the doorbell and write enable are low, and ready is high.
- R2: The first beat of a packet is accepted only when (input count − sampled output count) mod 16 is less than 2. Otherwise ready is low and the beat is held off.
- R3: The sampled output count is bits [3:0] of the status word. Bits [15:4] have no effect on ready.
- R4: The slot index is 0 for the first packet after reset and alternates 0/1 on every accepted final beat. It is held constant for all beats of one packet.
- R5: The doorbell is high for exactly the one cycle that follows the accepted final beat of a packet, and at no other time.
- R6: Both counts are 4 bits wide and wrap modulo 16. Admission stays correct after more than 16 packets.
- R7: The status word is registered every cycle. A change in the output count affects ready in the cycle after it is presented.
- R8: Once the first beat of a packet has been accepted, ready stays high until the final beat is accepted, including cycles with valid low.
- R9: The write enable is high exactly in cycles where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid_i | input | 1 | Producer offers a beat |
| pkt_last_i | input | 1 | Offered beat is the final beat of its packet |
| pkt_ready_o | output | 1 | Beat may be accepted this cycle |
| status_i | input | STAT_W (16) | Consumer status word; output count in bits [3:0] |
| wr_en_o | output | 1 | Write the accepted beat into the selected slot |
| slot_o | output | SLOT_W (1) | Target slot index |
| doorbell_o | output | 1 | One-cycle notice to the consumer that a packet is complete |

## Verification
Ready, write enable and slot index are combinational from registered state and the present inputs, so they are due in the same cycle the inputs are driven. The doorbell is due one clock edge after the final beat is accepted. A new status value reaches ready one edge after it is driven. The bench drives inputs on the falling edge and samples all outputs 1 ns later. The expected state is moved forward at each rising edge, so every check lands in the cycle where its result is due.

// File: rtl/adm_pkg.sv
package adm_pkg;

  // Sequencer phase: waiting for a packet head, or inside an admitted packet
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BODY = 1'b1
  } phase_e;

endpackage

// File: rtl/adm_status_sampler.sv
module adm_status_sampler #(
  parameter int unsigned STAT_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_i,
  output logic [CNT_W-1:0]  out_cnt_o
);

  logic [CNT_W-1:0] samp_d;
  logic [CNT_W-1:0] samp_q;

  // Only the count field is kept; upper status bits are dropped here
  always_comb begin
    samp_d = status_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
    end else begin
      samp_q <= samp_d;
    end
  end

  assign out_cnt_o = samp_q;

endmodule

// File: rtl/adm_occupancy.sv
module adm_occupancy #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned NUM_SLOTS = 2
) (
  input  logic [CNT_W-1:0] in_cnt_i,
  input  logic [CNT_W-1:0] out_cnt_i,
  output logic [CNT_W-1:0] occ_o,
  output logic             room_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NUM_SLOTS);

  // Modulo subtraction keeps the difference valid across counter wrap
  always_comb begin
    occ_o  = in_cnt_i - out_cnt_i;
    room_o = (occ_o < LIMIT);
  end

endmodule

// File: rtl/adm_slot_seq.sv
module adm_slot_seq #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned SLOT_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_acc_i,
  input  logic              beat_last_i,
  output logic [CNT_W-1:0]  in_cnt_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              busy_o,
  output logic              doorbell_o
);

  import adm_pkg::*;

  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(NUM_SLOTS - 1);

  phase_e            ph_d,    ph_q;
  logic [CNT_W-1:0]  cnt_d,   cnt_q;
  logic [SLOT_W-1:0] slot_d,  slot_q;
  logic              bell_d,  bell_q;
  logic              pkt_done;
  logic              cnt_en;

  assign pkt_done = beat_acc_i & beat_last_i;
  assign cnt_en   = pkt_done;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    bell_d = pkt_done;
    if (beat_acc_i) begin
      ph_d = beat_last_i ? PH_IDLE : PH_BODY;
    end
    if (cnt_en) begin
      cnt_d  = cnt_q + CNT_W'(1);
      slot_d = (slot_q == SLOT_MAX) ? '0 : slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      slot_q <= '0;
      bell_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bell_q <= bell_d;
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        slot_q <= slot_d;
      end
    end
  end

  assign in_cnt_o   = cnt_q;
  assign slot_o     = slot_q;
  assign busy_o     = (ph_q == PH_BODY);
  assign doorbell_o = bell_q;

  // R4: slot changes after each completed packet
  a_r4_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc_i && beat_last_i) |=> (slot_q != $past(slot_q)));

  // R4: slot held across the beats of one packet
  a_r4_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!(beat_acc_i && beat_last_i)) |=> $stable(slot_q));

  // R5: doorbell follows a completed packet
  a_r5_bell_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc_i && beat_last_i) |=> doorbell_o);

  // R5: no doorbell without a completed packet in the prior cycle
  a_r5_bell_only_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!(beat_acc_i && beat_last_i)) |=> !doorbell_o);

  // R6: input count steps by one modulo the counter width
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_acc_i && beat_last_i) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

endmodule

// File: rtl/dbuf_tx_admit.sv
module dbuf_tx_admit #(
  parameter  int unsigned NUM_SLOTS = 2,
  parameter  int unsigned CNT_W     = 4,
  parameter  int unsigned STAT_W    = 16,
  localparam int unsigned SLOT_W    = (NUM_SLOTS > 2) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid_i,
  input  logic              pkt_last_i,
  output logic              pkt_ready_o,
  input  logic [STAT_W-1:0] status_i,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              doorbell_o
);

  logic [CNT_W-1:0] out_cnt;
  logic [CNT_W-1:0] in_cnt;
  logic [CNT_W-1:0] occ;
  logic             room;
  logic             busy;
  logic             beat_acc;

  adm_status_sampler #(
    .STAT_W (STAT_W),
    .CNT_W  (CNT_W)
  ) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_i  (status_i),
    .out_cnt_o (out_cnt)
  );

  adm_occupancy #(
    .CNT_W     (CNT_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_occ (
    .in_cnt_i  (in_cnt),
    .out_cnt_i (out_cnt),
    .occ_o     (occ),
    .room_o    (room)
  );

  adm_slot_seq #(
    .CNT_W     (CNT_W),
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_acc_i  (beat_acc),
    .beat_last_i (pkt_last_i),
    .in_cnt_o    (in_cnt),
    .slot_o      (slot_o),
    .busy_o      (busy),
    .doorbell_o  (doorbell_o)
  );

  // Body beats bypass the occupancy check; heads need a free slot
  assign pkt_ready_o = busy | room;
  assign beat_acc    = pkt_valid_i & pkt_ready_o;
  assign wr_en_o     = beat_acc;

  // R2: a packet head is never written while both slots are taken
  a_r2_no_head_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_i && !busy && (occ >= CNT_W'(NUM_SLOTS))) |-> !wr_en_o);

  // R8: once inside a packet, the producer is never held off
  a_r8_body_open: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !pkt_last_i) |=> pkt_ready_o);

endmodule

// File: tb/dbuf_tx_admit_tb_top.sv
module dbuf_tx_admit_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NROWS      = 14;

  typedef struct packed {
    logic        v;
    logic        l;
    logic [15:0] st;
    logic        rdy;
    logic        wr;
    logic        sl;
    logic        db;
  } vec_t;

  // stimulus: valid, last, status | expected: ready, wr_en, slot, doorbell
  localparam vec_t TBL [NROWS] = '{
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'hA000, 1'b1, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b1, 16'hA000, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b1, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'hFFF1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 16'hFFF3, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 16'hFFF3, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b0, 16'hFFF3, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 16'hFFF3, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b0, 1'b0, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b0, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        valid;
  logic        last;
  logic [15:0] status;
  logic        ready;
  logic        wr_en;
  logic [0:0]  slot;
  logic        doorbell;

  int n_chk;
  int n_fail;
  bit finished;

  // reference state
  logic [3:0] in_m;
  logic [3:0] outq_m;
  logic       slot_m;
  logic       inpkt_m;
  logic       db_m;
  int         stalls;
  int         pkts;

  dbuf_tx_admit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_valid_i (valid),
    .pkt_last_i  (last),
    .pkt_ready_o (ready),
    .status_i    (status),
    .wr_en_o     (wr_en),
    .slot_o      (slot),
    .doorbell_o  (doorbell)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // one model-checked cycle: drive at falling edge, sample 1 ns later
  task automatic step(input logic v, input logic l, input logic [15:0] st);
    logic [3:0] occ;
    logic       er;
    logic       acc;
    @(negedge clk);
    valid  = v;
    last   = l;
    status = st;
    occ = in_m - outq_m;
    er  = inpkt_m | (occ < 4'd2);
    #1;
    check(ready == er,     "R6/R2 ready",    int'(ready), int'(er));
    check(wr_en == (v & er), "R9 wr_en",      int'(wr_en), int'(v & er));
    check(slot == slot_m,  "R4 slot",        int'(slot),  int'(slot_m));
    check(doorbell == db_m, "R5 doorbell",   int'(doorbell), int'(db_m));
    if (v && !er) stalls++;
    acc    = v & er;
    db_m   = acc & l;
    outq_m = st[3:0];
    if (acc && l) begin
      in_m    = in_m + 4'd1;
      slot_m  = ~slot_m;
      inpkt_m = 1'b0;
      pkts++;
    end else if (acc) begin
      inpkt_m = 1'b1;
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    stalls = 0; pkts = 0;
    rst_n = 1'b0; valid = 1'b0; last = 1'b0; status = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    // R1: values held during reset
    check(ready == 1'b1,    "R1 ready in reset",    int'(ready), 1);
    check(slot == 1'b0,     "R1 slot in reset",     int'(slot), 0);
    check(doorbell == 1'b0, "R1 doorbell in reset", int'(doorbell), 0);
    check(wr_en == 1'b0,    "R1 wr_en in reset",    int'(wr_en), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      valid  = TBL[i].v;
      last   = TBL[i].l;
      status = TBL[i].st;
      #1;
      check(ready == TBL[i].rdy,   $sformatf("R2/R3/R7/R8 ready row %0d", i), int'(ready), int'(TBL[i].rdy));
      check(wr_en == TBL[i].wr,    $sformatf("R9 wr_en row %0d", i), int'(wr_en), int'(TBL[i].wr));
      check(slot == TBL[i].sl,     $sformatf("R4 slot row %0d", i), int'(slot), int'(TBL[i].sl));
      check(doorbell == TBL[i].db, $sformatf("R5 doorbell row %0d", i), int'(doorbell), int'(TBL[i].db));
    end

    // one more packet so slot and doorbell are non-zero, then reset mid-run (R1)
    @(negedge clk);
    valid = 1'b1; last = 1'b1; status = 16'h0003;
    #1;
    check(wr_en == 1'b1, "R2 accept before reset", int'(wr_en), 1);
    @(negedge clk);
    valid = 1'b0; last = 1'b0; status = 16'h0000;
    #1;
    check(slot == 1'b1 && doorbell == 1'b1, "R5 pre-reset state", int'({slot, doorbell}), 3);
    rst_n = 1'b0;
    #1;
    check(slot == 1'b0,     "R1 slot after reset",     int'(slot), 0);
    check(doorbell == 1'b0, "R1 doorbell after reset", int'(doorbell), 0);
    check(ready == 1'b1,    "R1 ready after reset",    int'(ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    in_m = 4'd0; outq_m = 4'd0; slot_m = 1'b0; inpkt_m = 1'b0; db_m = 1'b0;

    // R6: long run past counter wrap, consumer slower than producer
    begin
      logic [3:0] rel;
      rel = 4'd0;
      for (int k = 0; k < 120; k++) begin
        if ((k % 3) == 0 && (in_m != rel)) rel = rel + 4'd1;
        step(1'b1, (k % 3) != 0, {12'hC5A, rel});
      end
    end
    check(pkts > 16,  "R6 counter wrapped", pkts, 17);
    check(stalls > 0, "R2 stalls seen after wrap", stalls, 1);

    step(1'b0, 1'b0, 16'h0000);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    finish_run();
  end

endmodule